// File: doc/BRIEF.md
# Per-Processor Cascaded Tick Timer

This block is a local event timer, one copy per processor core. A prescaler down-counter reloads from a programmable tick period and emits one tick every (period + 1) clocks. A second down-counter consumes those ticks, starting from a programmable interrupt count. When that count runs out it raises an interrupt flag. In one-shot mode the flag fires once. In interval mode the second counter reloads itself and keeps firing until software stops it.

Software controls the block through a small 32-bit word-addressed register port. Writes are single-cycle and reads are combinational. The register port offers the two buffers, a control word, interrupt enable and status, and a write-acknowledge word that software polls after each write. The live values of both counters can also be read back. The interrupt count buffer is only updated when the written word carries an update flag in bit 31. This lets software rewrite the word without disturbing the count.

Word map (addr_i): 0 tick period, 1 interrupt count (bit 31 update flag, bits 30:0 count), 2 control, 3 interrupt status, 4 interrupt enable, 5 write acknowledge, 6 live interrupt count (read-only), 7 live tick count (read-only).

Top module: `tick_timer`

## Requirements
- R1: After reset, every readable word (addresses 0 to 7) reads zero and irq_o is low.
- R2: While running, the interrupt counter advances once every (P + 1) clocks, where P is the tick period. The interrupt therefore appears N*(P+1) clocks after the start write, for a count N; P = 1 halves the tick rate and P = 0 ticks every clock.
- R3: A write to word 1 with bit 31 = 1 loads bits 30:0 into both the count buffer and the live interrupt counter. With bit 31 = 0, neither is changed.
- R4: Control word bit 0 runs the tick counter and bit 1 lets the interrupt counter consume ticks. With bit 1 clear, the interrupt counter holds its value. Setting bit 1 from clear reloads the interrupt counter from its buffer.
- R5: With control bit 2 clear (one-shot), the interrupt counter stops at zero after it expires, and no further interrupt is raised.
- R6: With control bit 2 set (interval), the interrupt counter reloads from its buffer on expiry. A new expiry follows every N*(P+1) clocks.
- R7: A write to word 0, word 1 (whatever bit 31 holds) or word 2 sets bit 0, 1 or 3 respectively of word 5. Writing 1 to a bit of word 5 clears that bit.
- R8: Bit 0 of word 3 is set on expiry and cleared by writing 1 to it. irq_o is high exactly when that bit and bit 0 of word 4 are both set.
- R9: Clearing control bit 0 freezes the live tick count. Setting it again from clear reloads the tick count from the period.
- R10: Counts from 0xF up to 0x7FFFFFFF are accepted. A write of 0xFFFFFFFF to word 1 reads back as 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read otherwise |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The bench measures the exact clock count from the start write to irq_o for several period and count pairs, including period zero and the minimum count of 0xF. An off-by-one in the prescaler reload or the expiry compare shows up there as an interval one tick or one clock too long or too short. It rewrites the count word without the update flag and reads back both the buffer and the live counter. A design that ignored the flag would overwrite them. It runs one-shot past a second full interval and interval mode through two expiries; a swapped mode would either refire or go silent. It freezes the tick counter mid-count and checks that the value holds and then reloads on restart. A design that kept counting, or resumed without reloading, would read a different value.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_TICKB = 3'd0,
    RA_ICNTB = 3'd1,
    RA_CTRL  = 3'd2,
    RA_STAT  = 3'd3,
    RA_INTEN = 3'd4,
    RA_WSTAT = 3'd5,
    RA_ICNT  = 3'd6,
    RA_TCNT  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic interval;
    logic int_run;
    logic tick_run;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int WSTAT_W  = 4;
  localparam int WS_TICKB = 0;
  localparam int WS_ICNTB = 1;
  localparam int WS_CTRL  = 3;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int TICK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [TICK_W-1:0] period_i,
  output logic              tick_o,
  output logic [TICK_W-1:0] cnt_o
);

  logic [TICK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= period_i;
    else if (run_i)  cnt_q <= (cnt_q == '0) ? period_i : cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/tt_irq_counter.sv
module tt_irq_counter #(
  parameter int ICNT_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ICNT_W-1:0] load_val_i,
  input  logic [ICNT_W-1:0] reload_i,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              interval_i,
  output logic              expire_o,
  output logic [ICNT_W-1:0] cnt_o
);

  localparam logic [ICNT_W-1:0] ONE = ICNT_W'(1);

  logic [ICNT_W-1:0] cnt_q;
  logic              step;

  // a count of zero is idle; the compare sits one above zero so expiry and the
  // return to zero land on the same edge
  assign step     = !load_i && tick_i && run_i && (cnt_q != '0);
  assign expire_o = step && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (expire_o) cnt_q <= interval_i ? reload_i : '0;
    else if (step)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tt_regfile.sv
module tt_regfile
  import tick_timer_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               expire_i,
  input  logic [ICNT_W-1:0]  icnt_i,
  input  logic [TICK_W-1:0]  tcnt_i,
  output logic [TICK_W-1:0]  tick_buf_o,
  output logic [ICNT_W-1:0]  icnt_buf_o,
  output ctrl_t              ctrl_o,
  output logic               load_tick_o,
  output logic               load_icnt_o,
  output logic [ICNT_W-1:0]  load_val_o,
  output logic               int_stat_o,
  output logic               int_en_o,
  output logic [WSTAT_W-1:0] wstat_o
);

  localparam int UPD_BIT = DATA_W - 1;

  reg_sel_e           sel;
  logic               wr;
  logic               wr_tickb, wr_icntb, wr_ctrl, wr_stat, wr_inten, wr_wstat;
  logic               buf_upd, int_rise;
  ctrl_t              ctrl_q, ctrl_wd;
  logic [TICK_W-1:0]  tick_buf_q;
  logic [ICNT_W-1:0]  icnt_buf_q;
  logic               stat_q, en_q;
  logic [WSTAT_W-1:0] wstat_q, wstat_d;

  assign sel      = reg_sel_e'(addr_i);
  assign wr       = req_i && we_i;
  assign wr_tickb = wr && (sel == RA_TICKB);
  assign wr_icntb = wr && (sel == RA_ICNTB);
  assign wr_ctrl  = wr && (sel == RA_CTRL);
  assign wr_stat  = wr && (sel == RA_STAT);
  assign wr_inten = wr && (sel == RA_INTEN);
  assign wr_wstat = wr && (sel == RA_WSTAT);
  assign ctrl_wd  = ctrl_t'(wdata_i[CTRL_W-1:0]);

  assign buf_upd     = wr_icntb && wdata_i[UPD_BIT];
  assign int_rise    = wr_ctrl && ctrl_wd.int_run && !ctrl_q.int_run;
  assign load_tick_o = wr_ctrl && ctrl_wd.tick_run && !ctrl_q.tick_run;
  assign load_icnt_o = buf_upd || int_rise;
  assign load_val_o  = buf_upd ? wdata_i[ICNT_W-1:0] : icnt_buf_q;

  always_comb begin
    wstat_d = wstat_q;
    if (wr_wstat) wstat_d = wstat_q & ~wdata_i[WSTAT_W-1:0];
    if (wr_tickb) wstat_d[WS_TICKB] = 1'b1;
    if (wr_icntb) wstat_d[WS_ICNTB] = 1'b1;
    if (wr_ctrl)  wstat_d[WS_CTRL]  = 1'b1;
    wstat_d[2] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_buf_q <= '0;
      icnt_buf_q <= '0;
      ctrl_q     <= '0;
      stat_q     <= 1'b0;
      en_q       <= 1'b0;
      wstat_q    <= '0;
    end else begin
      if (wr_tickb) tick_buf_q <= wdata_i[TICK_W-1:0];
      if (buf_upd)  icnt_buf_q <= wdata_i[ICNT_W-1:0];
      if (wr_ctrl)  ctrl_q     <= ctrl_wd;
      if (wr_inten) en_q       <= wdata_i[0];
      // expiry wins over a same-cycle clear
      if (expire_i)                  stat_q <= 1'b1;
      else if (wr_stat && wdata_i[0]) stat_q <= 1'b0;
      wstat_q <= wstat_d;
    end
  end

  always_comb begin
    case (sel)
      RA_TICKB: rdata_o = DATA_W'(tick_buf_q);
      RA_ICNTB: rdata_o = DATA_W'(icnt_buf_q);
      RA_CTRL:  rdata_o = DATA_W'(ctrl_q);
      RA_STAT:  rdata_o = DATA_W'(stat_q);
      RA_INTEN: rdata_o = DATA_W'(en_q);
      RA_WSTAT: rdata_o = DATA_W'(wstat_q);
      RA_ICNT:  rdata_o = DATA_W'(icnt_i);
      RA_TCNT:  rdata_o = DATA_W'(tcnt_i);
      default:  rdata_o = '0;
    endcase
  end

  assign tick_buf_o = tick_buf_q;
  assign icnt_buf_o = icnt_buf_q;
  assign ctrl_o     = ctrl_q;
  assign int_stat_o = stat_q;
  assign int_en_o   = en_q;
  assign wstat_o    = wstat_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  ctrl_t              ctrl;
  logic               tick, expire, load_tick, load_icnt;
  logic               int_stat, int_en;
  logic [TICK_W-1:0]  tick_buf, tcnt;
  logic [ICNT_W-1:0]  icnt_buf, icnt, load_val;
  logic [WSTAT_W-1:0] wstat;

  tt_regfile #(.TICK_W(TICK_W), .ICNT_W(ICNT_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .expire_i   (expire),
    .icnt_i     (icnt),
    .tcnt_i     (tcnt),
    .tick_buf_o (tick_buf),
    .icnt_buf_o (icnt_buf),
    .ctrl_o     (ctrl),
    .load_tick_o(load_tick),
    .load_icnt_o(load_icnt),
    .load_val_o (load_val),
    .int_stat_o (int_stat),
    .int_en_o   (int_en),
    .wstat_o    (wstat)
  );

  tt_prescaler #(.TICK_W(TICK_W)) i_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (ctrl.tick_run),
    .load_i  (load_tick),
    .period_i(tick_buf),
    .tick_o  (tick),
    .cnt_o   (tcnt)
  );

  tt_irq_counter #(.ICNT_W(ICNT_W)) i_icnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_icnt),
    .load_val_i(load_val),
    .reload_i  (icnt_buf),
    .tick_i    (tick),
    .run_i     (ctrl.int_run),
    .interval_i(ctrl.interval),
    .expire_o  (expire),
    .cnt_o     (icnt)
  );

  assign irq_o = int_stat && int_en;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               upd_i,
  input logic               tick_i,
  input logic               expire_i,
  input logic               tick_run_i,
  input logic               int_run_i,
  input logic               interval_i,
  input logic               int_stat_i,
  input logic [TICK_W-1:0]  tick_buf_i,
  input logic [TICK_W-1:0]  tcnt_i,
  input logic [ICNT_W-1:0]  icnt_i,
  input logic [ICNT_W-1:0]  icnt_buf_i,
  input logic [WSTAT_W-1:0] wstat_i
);

  logic wr_ctrl, wr_icntb;
  assign wr_ctrl  = req_i && we_i && (addr_i == RA_CTRL);
  assign wr_icntb = req_i && we_i && (addr_i == RA_ICNTB);

  assert_tick_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && tick_run_i) |=> (tcnt_i == $past(tick_buf_i)));

  assert_no_update_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_icntb && !upd_i) |=> $stable(icnt_buf_i));

  assert_int_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_run_i && !wr_ctrl && !wr_icntb) |=> $stable(icnt_i));

  assert_oneshot_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !interval_i) |=> (icnt_i == '0));

  assert_interval_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && interval_i) |=> (icnt_i == $past(icnt_buf_i)));

  assert_wack_ctrl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> wstat_i[WS_CTRL]);

  assert_stat_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_stat_i) |-> $past(expire_i));

  assert_tick_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_run_i && !wr_ctrl) |=> $stable(tcnt_i));

endmodule

bind tick_timer tick_timer_chk #(.TICK_W(TICK_W), .ICNT_W(ICNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .upd_i      (wdata_i[31]),
  .tick_i     (tick),
  .expire_i   (expire),
  .tick_run_i (ctrl.tick_run),
  .int_run_i  (ctrl.int_run),
  .interval_i (ctrl.interval),
  .int_stat_i (int_stat),
  .tick_buf_i (tick_buf),
  .tcnt_i     (tcnt),
  .icnt_i     (icnt),
  .icnt_buf_i (icnt_buf),
  .wstat_i    (wstat)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_TICKB = 3'd0, A_ICNTB = 3'd1, A_CTRL = 3'd2, A_STAT = 3'd3,
                         A_INTEN = 3'd4, A_WSTAT = 3'd5, A_ICNT = 3'd6, A_TCNT = 3'd7;
  localparam logic [31:0] UPD = 32'h8000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  tick_timer i_tick_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_irq(input int t0, input int lim, output int took);
    while (!irq_o && (cyc - t0) < lim) @(negedge clk_i);
    took = cyc - t0;
  endtask

  task automatic quiesce();
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd("R1 reset word", 3'(a), 32'h0);
    chk("R1 reset irq", 32'(irq_o), 32'h0);
  endtask

  task automatic t_period(input string tag, input int p, input int n, input int exp);
    int t0, took;
    wr(A_INTEN, 32'h1);
    wr(A_TICKB, 32'(p));
    wr(A_ICNTB, UPD | 32'(n));
    wr(A_CTRL, 32'h3);
    t0 = cyc;
    wait_irq(t0, exp + 20, took);
    chk(tag, 32'(took), 32'(exp));
    quiesce();
  endtask

  task automatic t_oneshot();
    int t0, took;
    wr(A_TICKB, 32'd1);
    wr(A_ICNTB, UPD | 32'd3);
    wr(A_CTRL, 32'h3);
    t0 = cyc;
    wait_irq(t0, 40, took);
    chk("R5 first expiry", 32'(took), 32'd6);
    wr(A_STAT, 32'h1);
    idle(30);
    rd("R5 no refire", A_STAT, 32'h0);
    chk("R5 irq low", 32'(irq_o), 32'h0);
    rd("R5 count parked", A_ICNT, 32'h0);
    quiesce();
  endtask

  task automatic t_interval();
    int t0, took;
    wr(A_TICKB, 32'd2);
    wr(A_ICNTB, UPD | 32'd5);
    wr(A_CTRL, 32'h7);
    t0 = cyc;
    wait_irq(t0, 50, took);
    chk("R6 first expiry", 32'(took), 32'd15);
    wr(A_STAT, 32'h1);
    wait_irq(t0, 60, took);
    chk("R6 second expiry", 32'(took), 32'd30);
    quiesce();
  endtask

  task automatic t_update_flag();
    wr(A_ICNTB, UPD | 32'd9);
    rd("R3 buffer loaded", A_ICNTB, 32'd9);
    rd("R3 counter loaded", A_ICNT, 32'd9);
    wr(A_ICNTB, 32'd5);
    rd("R3 buffer kept", A_ICNTB, 32'd9);
    rd("R3 counter kept", A_ICNT, 32'd9);
    wr(A_ICNTB, 32'hFFFF_FFFF);
    rd("R10 max buffer", A_ICNTB, 32'h7FFF_FFFF);
    rd("R10 max counter", A_ICNT, 32'h7FFF_FFFF);
  endtask

  task automatic t_int_gate();
    int t0, took;
    wr(A_TICKB, 32'd0);
    wr(A_ICNTB, UPD | 32'd4);
    wr(A_CTRL, 32'h1);
    idle(10);
    rd("R4 count held", A_ICNT, 32'd4);
    rd("R4 no expiry", A_STAT, 32'h0);
    wr(A_CTRL, 32'h3);
    t0 = cyc;
    wait_irq(t0, 20, took);
    chk("R4 run after enable", 32'(took), 32'd4);
    quiesce();
  endtask

  task automatic t_freeze();
    wr(A_TICKB, 32'd9);
    wr(A_CTRL, 32'h1);
    idle(3);
    rd("R9 running", A_TCNT, 32'd6);
    wr(A_CTRL, 32'h0);
    rd("R9 stop edge", A_TCNT, 32'd5);
    idle(5);
    rd("R9 frozen", A_TCNT, 32'd5);
    wr(A_CTRL, 32'h1);
    rd("R9 reload on start", A_TCNT, 32'd9);
    quiesce();
  endtask

  task automatic t_wack();
    wr(A_WSTAT, 32'hF);
    rd("R7 cleared", A_WSTAT, 32'h0);
    wr(A_TICKB, 32'd0);
    rd("R7 period ack", A_WSTAT, 32'h1);
    wr(A_ICNTB, 32'd0);
    rd("R7 count ack", A_WSTAT, 32'h3);
    wr(A_CTRL, 32'h0);
    rd("R7 ctrl ack", A_WSTAT, 32'hB);
    wr(A_WSTAT, 32'h2);
    rd("R7 single clear", A_WSTAT, 32'h9);
    wr(A_WSTAT, 32'h9);
    rd("R7 rest clear", A_WSTAT, 32'h0);
  endtask

  task automatic t_irq_gate();
    wr(A_INTEN, 32'h0);
    wr(A_TICKB, 32'd0);
    wr(A_ICNTB, UPD | 32'd2);
    wr(A_CTRL, 32'h3);
    idle(5);
    rd("R8 status set", A_STAT, 32'h1);
    chk("R8 masked irq", 32'(irq_o), 32'h0);
    wr(A_INTEN, 32'h1);
    chk("R8 unmasked irq", 32'(irq_o), 32'h1);
    wr(A_STAT, 32'h1);
    rd("R8 status cleared", A_STAT, 32'h0);
    chk("R8 irq dropped", 32'(irq_o), 32'h0);
    quiesce();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_period("R2 half rate", 1, 3, 6);
    t_period("R2 every clock", 0, 4, 4);
    t_period("R10 min count", 3, 15, 60);
    t_oneshot();
    t_interval();
    t_update_flag();
    t_int_gate();
    t_freeze();
    t_wack();
    t_irq_gate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule